// File: doc/BRIEF.md
# Serial Flash Erase Command Engine

This block is the device-side command logic that handles erasure in a serial flash. It watches a mode-0 serial port (active-low select, serial clock, data in, data out). The serial lines are brought into the system clock domain, and the engine assembles bytes from them. It keeps a write-enable latch. When select is released on a valid frame boundary, it decides whether to launch a sector erase or a whole-array erase. The erase itself is represented by a self-timed busy window of a fixed number of system clocks. During that window the block drives an erase request to the array, together with the sector index or an all-sectors flag.

A status-read command lets the host poll progress. The status byte carries:
- the busy flag in bit 0,
- the write-enable latch in bit 1,
- the three protection-level bits in bits 4:2, with the most significant level bit in bit 4.

Those protection bits come from a quasi-static input. They decide which sectors can be erased: a non-zero level fences off the upper part of the array, and the top level fences off all of it.

Top module: `erase_cmd_engine`

## Requirements
- R1: After reset, erase_req is 0, miso is 0, and a status read with blk_prot = 0 returns 8'h00.
- R2: Opcode 8'h06, given as one complete byte with select released right after it, sets the write-enable latch. The status read (opcode 8'h05) returns {3'b000, blk_prot[2:0], wel, wip}, most significant bit first, starting on the falling clock edge after the opcode's eighth bit.
- R3: Opcode 8'hD8 followed by three address bytes, most significant byte first, erases the sector given by the top SECT_W address bits. The lower address bits have no effect on which sector is chosen.
- R4: Opcode 8'hC7 with no address erases the whole array, signalled by erase_all = 1 while erase_req is high.
- R5: Neither erase opcode has any effect unless the write-enable latch is set.
- R6: An erase frame is discarded unless select rises with the bit count on a byte boundary and the byte count exactly 1 (whole-array erase) or 4 (sector erase). A discarded frame leaves the write-enable latch unchanged.
- R7: An accepted erase starts only after select rises. While select is still low, erase_req stays 0.
- R8: The status busy flag reads 1 for the whole erase. erase_req is high for exactly SE_CYCLES system clocks for a sector erase and BE_CYCLES for a whole-array erase, and then the busy flag reads 0.
- R9: The write-enable latch is cleared in the cycle the erase starts.
- R10: With protection level p, where 1 ≤ p ≤ 6, sectors at index NSECT − (NSECT >> (7 − p)) and above are locked; level 7 locks every sector. An erase of a locked sector is not run. A whole-array erase runs only when the level is 0. A refused erase keeps the write-enable latch set.
- R11: While an erase is running, every opcode except status read is ignored. This includes write enable and both erase opcodes.
- R12: Keeping select low after a status-read opcode repeats the status byte, one byte after another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock, idle low (mode 0) |
| mosi | input | 1 | Serial data into the device, sampled on rising sck |
| miso | output | 1 | Serial data out, changed on falling sck; 0 while deselected |
| blk_prot | input | 3 | Protection level (quasi-static) |
| erase_req | output | 1 | High for the duration of the erase cycle |
| erase_all | output | 1 | Erase targets the whole array; valid while erase_req is high |
| erase_sector | output | SECT_W | Sector being erased; valid while erase_req is high and erase_all is low |

## Verification
The properties assume that the serial clock is much slower than the system clock. Each sck level must last longer than the synchronizer latency plus one cycle, so every edge becomes exactly one event. They also assume that select never changes in the same synchronized cycle as an sck edge, and that blk_prot changes only while select is high and no erase runs. The stimulus holds each sck level for six system clocks and lets half a serial period pass around every select transition. It changes the protection level only between frames while the array is idle, so every frame boundary and busy window that is checked sits inside those assumptions.

// File: rtl/erase_eng_pkg.sv
package erase_eng_pkg;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_SERS = 8'hD8;
  localparam logic [7:0] OP_BERS = 8'hC7;

  typedef enum logic [1:0] {
    FR_NONE,
    FR_WREN,
    FR_SECTOR,
    FR_BULK
  } frame_kind_t;

  // Classify a completed frame from its opcode, length and alignment.
  function automatic frame_kind_t classify_frame(input logic [7:0] op,
                                                 input logic [2:0] nbytes,
                                                 input logic       aligned,
                                                 input logic [2:0] sector_len);
    frame_kind_t k;
    k = FR_NONE;
    if (aligned) begin
      if (op == OP_WREN && nbytes == 3'd1)            k = FR_WREN;
      else if (op == OP_BERS && nbytes == 3'd1)       k = FR_BULK;
      else if (op == OP_SERS && nbytes == sector_len) k = FR_SECTOR;
    end
    return k;
  endfunction

  // Level 0 locks nothing, level 7 locks all, others lock the top share.
  function automatic logic sector_locked(input int unsigned sector,
                                         input int unsigned nsect,
                                         input logic [2:0]  level);
    int unsigned span;
    if (level == 3'd0) return 1'b0;
    if (level == 3'd7) return 1'b1;
    span = nsect >> (3'd7 - level);
    return (sector >= nsect - span);
  endfunction

  function automatic logic [7:0] pack_status(input logic       busy,
                                             input logic       wel,
                                             input logic [2:0] level);
    return {3'b000, level, wel, busy};
  endfunction

endpackage

// File: rtl/erase_sync.sv
module erase_sync #(
  parameter int       W       = 1,
  parameter int       STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= RST_VAL;
        else        pipe <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= {STAGES{RST_VAL}};
        else        pipe <= {pipe[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/erase_spi_front.sv
module erase_spi_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       mosi,
  input  logic       rd_mode,
  input  logic [7:0] status_byte,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic [2:0] byte_idx,
  output logic       frame_end,
  output logic       frame_aligned,
  output logic [2:0] frame_bytes,
  output logic       miso
);
  logic [2:0] raw_s;
  logic       cs_s, sck_s, mosi_s;
  logic       cs_prev, sck_prev;
  logic       sck_rise, sck_fall;
  logic [6:0] shreg;
  logic [2:0] bit_cnt;
  logic [2:0] nbytes;

  erase_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({cs_n, sck, mosi}),
    .q    (raw_s)
  );

  assign cs_s   = raw_s[2];
  assign sck_s  = raw_s[1];
  assign mosi_s = raw_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev  <= 1'b1;
      sck_prev <= 1'b0;
    end else begin
      cs_prev  <= cs_s;
      sck_prev <= sck_s;
    end
  end

  assign sck_rise  = sck_s & ~sck_prev & ~cs_s;
  assign sck_fall  = ~sck_s & sck_prev & ~cs_s;
  assign frame_end = cs_s & ~cs_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
      nbytes  <= '0;
    end else if (cs_s) begin
      bit_cnt <= '0;
      nbytes  <= '0;
    end else if (sck_rise) begin
      shreg   <= {shreg[5:0], mosi_s};
      bit_cnt <= bit_cnt + 3'd1;
      if (bit_cnt == 3'd7 && nbytes != 3'd7) nbytes <= nbytes + 3'd1;
    end
  end

  assign byte_done     = sck_rise && (bit_cnt == 3'd7);
  assign rx_byte       = {shreg, mosi_s};
  assign byte_idx      = nbytes;
  assign frame_aligned = (bit_cnt == 3'd0);
  assign frame_bytes   = nbytes;

  // Output bit index is the complement of the count of bits received.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  miso <= 1'b0;
    else if (cs_s)               miso <= 1'b0;
    else if (sck_fall && rd_mode) miso <= status_byte[~bit_cnt];
  end
endmodule

// File: rtl/erase_cmd_ctrl.sv
module erase_cmd_ctrl
  import erase_eng_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SECT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done,
  input  logic [7:0]        rx_byte,
  input  logic [2:0]        byte_idx,
  input  logic              frame_end,
  input  logic              frame_aligned,
  input  logic [2:0]        frame_bytes,
  input  logic              busy,
  input  logic [2:0]        blk_prot,
  output logic              rd_mode,
  output logic              start,
  output logic              start_all,
  output logic [SECT_W-1:0] start_sector,
  output logic              wel,
  output logic [7:0]        status_byte
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int NSECT      = 2 ** SECT_W;

  logic [7:0]        opcode;
  logic [ADDR_W-1:0] addr;
  frame_kind_t       kind;
  logic              locked;
  logic              accept_evt;
  logic              wren_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode <= '0;
      addr   <= '0;
    end else if (byte_done) begin
      if (byte_idx == 3'd0) opcode <= rx_byte;
      else                  addr   <= {addr[ADDR_W-9:0], rx_byte};
    end
  end

  assign kind         = classify_frame(opcode, frame_bytes, frame_aligned,
                                       3'(ADDR_BYTES + 1));
  assign start_sector = addr[ADDR_W-1 -: SECT_W];
  assign locked       = sector_locked(32'(start_sector), NSECT, blk_prot);
  assign accept_evt   = frame_end && !busy;
  assign wren_evt     = accept_evt && (kind == FR_WREN);
  assign start        = accept_evt && wel &&
                        (((kind == FR_SECTOR) && !locked) ||
                         ((kind == FR_BULK) && (blk_prot == 3'd0)));
  assign start_all    = (kind == FR_BULK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wel <= 1'b0;
    else if (start)    wel <= 1'b0;
    else if (wren_evt) wel <= 1'b1;
  end

  assign rd_mode     = (opcode == OP_RDSR) && (frame_bytes != 3'd0);
  assign status_byte = pack_status(busy, wel, blk_prot);
endmodule

// File: rtl/erase_timer.sv
module erase_timer #(
  parameter int SE_CYCLES = 20000,
  parameter int BE_CYCLES = 100000,
  parameter int SECT_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_all,
  input  logic [SECT_W-1:0] start_sector,
  output logic              busy,
  output logic              tgt_all,
  output logic [SECT_W-1:0] tgt_sector
);
  localparam int MAXC  = (BE_CYCLES > SE_CYCLES) ? BE_CYCLES : SE_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain     <= '0;
      tgt_all    <= 1'b0;
      tgt_sector <= '0;
    end else if (start) begin
      remain     <= start_all ? CNT_W'(BE_CYCLES) : CNT_W'(SE_CYCLES);
      tgt_all    <= start_all;
      tgt_sector <= start_all ? '0 : start_sector;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/erase_cmd_engine.sv
module erase_cmd_engine #(
  parameter int ADDR_W      = 24,
  parameter int SECT_W      = 8,
  parameter int SE_CYCLES   = 20000,
  parameter int BE_CYCLES   = 100000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              mosi,
  output logic              miso,
  input  logic [2:0]        blk_prot,
  output logic              erase_req,
  output logic              erase_all,
  output logic [SECT_W-1:0] erase_sector
);
  logic              byte_done;
  logic [7:0]        rx_byte;
  logic [2:0]        byte_idx;
  logic              frame_end;
  logic              frame_aligned;
  logic [2:0]        frame_bytes;
  logic              rd_mode;
  logic [7:0]        status_byte;
  logic              start_evt;
  logic              start_all;
  logic [SECT_W-1:0] start_sector;
  logic              wel;
  logic              busy;

  erase_spi_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .sck          (sck),
    .mosi         (mosi),
    .rd_mode      (rd_mode),
    .status_byte  (status_byte),
    .byte_done    (byte_done),
    .rx_byte      (rx_byte),
    .byte_idx     (byte_idx),
    .frame_end    (frame_end),
    .frame_aligned(frame_aligned),
    .frame_bytes  (frame_bytes),
    .miso         (miso)
  );

  erase_cmd_ctrl #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_done    (byte_done),
    .rx_byte      (rx_byte),
    .byte_idx     (byte_idx),
    .frame_end    (frame_end),
    .frame_aligned(frame_aligned),
    .frame_bytes  (frame_bytes),
    .busy         (busy),
    .blk_prot     (blk_prot),
    .rd_mode      (rd_mode),
    .start        (start_evt),
    .start_all    (start_all),
    .start_sector (start_sector),
    .wel          (wel),
    .status_byte  (status_byte)
  );

  erase_timer #(.SE_CYCLES(SE_CYCLES), .BE_CYCLES(BE_CYCLES), .SECT_W(SECT_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start_evt),
    .start_all   (start_all),
    .start_sector(start_sector),
    .busy        (busy),
    .tgt_all     (erase_all),
    .tgt_sector  (erase_sector)
  );

  assign erase_req = busy;
endmodule

// File: rtl/erase_cmd_engine_chk.sv
module erase_cmd_engine_chk #(
  parameter int SE_CYCLES = 20000,
  parameter int BE_CYCLES = 100000,
  parameter int SECT_W    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              start_all,
  input logic              frame_end,
  input logic              wel,
  input logic [2:0]        blk_prot,
  input logic              erase_req,
  input logic              erase_all,
  input logic [SECT_W-1:0] erase_sector
);
  int unsigned run_len;
  int unsigned want_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len  <= 0;
      want_len <= 0;
    end else if (start) begin
      run_len  <= 0;
      want_len <= start_all ? BE_CYCLES : SE_CYCLES;
    end else if (erase_req) begin
      run_len <= run_len + 1;
    end
  end

  a_r7_start_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> frame_end);

  a_r5_start_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> wel);

  a_r9_wel_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !wel);

  a_r11_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !erase_req);

  a_r10_bulk_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_all) |-> (blk_prot == 3'd0));

  a_r8_window_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(erase_req) |-> (run_len == want_len));

  a_r8_target_held: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && $past(erase_req)) |-> ($stable(erase_sector) && $stable(erase_all)));
endmodule

bind erase_cmd_engine erase_cmd_engine_chk #(
  .SE_CYCLES(SE_CYCLES),
  .BE_CYCLES(BE_CYCLES),
  .SECT_W   (SECT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start_evt),
  .start_all   (start_all),
  .frame_end   (frame_end),
  .wel         (wel),
  .blk_prot    (blk_prot),
  .erase_req   (erase_req),
  .erase_all   (erase_all),
  .erase_sector(erase_sector)
);

// File: tb/erase_cmd_engine_tb.sv
module erase_cmd_engine_tb;
  localparam int SE_C = 1500;
  localparam int BE_C = 3000;
  localparam int H    = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, sck, mosi;
  logic       miso;
  logic [2:0] blk_prot;
  logic       erase_req, erase_all;
  logic [7:0] erase_sector;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 0;

  typedef struct {
    bit       all;
    bit [7:0] sec;
    int       len;
  } exp_t;
  exp_t sb_q[$];

  erase_cmd_engine #(.SE_CYCLES(SE_C), .BE_CYCLES(BE_C)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso),
    .blk_prot(blk_prot), .erase_req(erase_req), .erase_all(erase_all),
    .erase_sector(erase_sector)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // Monitor: measure each erase window at the ports and compare to the queue.
  bit       prev_req = 0;
  int       run_len  = 0;
  bit       cap_all;
  bit [7:0] cap_sec;
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (erase_req) begin
        if (!prev_req) begin
          cap_all = erase_all;
          cap_sec = erase_sector;
          run_len = 0;
        end
        run_len++;
      end else if (prev_req) begin
        if (sb_q.size() == 0) begin
          chk("R5/R6/R10/R11", "unexpected erase", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk("R4", "erase_all", int'(cap_all), int'(e.all));
          if (!e.all) chk("R3", "erase_sector", int'(cap_sec), int'(e.sec));
          chk("R8", "window length", run_len, e.len);
        end
      end
      prev_req = erase_req;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      mosi = v[i];
      tick(H); sck = 1'b1;
      tick(H); sck = 1'b0;
    end
  endtask

  task automatic get_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      mosi = 1'b0;
      tick(H); v[i] = miso; sck = 1'b1;
      tick(H); sck = 1'b0;
    end
  endtask

  task automatic sel();
    cs_n = 1'b0; tick(H);
  endtask

  task automatic desel();
    tick(H); cs_n = 1'b1; tick(12);
  endtask

  task automatic rd_status(output logic [7:0] s);
    sel(); send_bits(8'h05, 8); get_byte(s); desel();
  endtask

  task automatic expect_status(input string req, input logic [7:0] exp);
    logic [7:0] s;
    rd_status(s);
    chk(req, "status", int'(s), int'(exp));
  endtask

  task automatic do_wren();
    sel(); send_bits(8'h06, 8); desel();
  endtask

  task automatic do_se(input logic [23:0] a, input bit ok);
    exp_t e;
    sel();
    send_bits(8'hD8, 8);
    send_bits(a[23:16], 8); send_bits(a[15:8], 8); send_bits(a[7:0], 8);
    if (ok) begin
      e.all = 0; e.sec = a[23:16]; e.len = SE_C;
      sb_q.push_back(e);
    end
    desel();
  endtask

  task automatic do_be(input bit ok);
    exp_t e;
    sel();
    send_bits(8'hC7, 8);
    if (ok) begin
      e.all = 1; e.sec = 8'h00; e.len = BE_C;
      sb_q.push_back(e);
    end
    desel();
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int k = 0; k < 100; k++) begin
      rd_status(s);
      if (!s[0]) return;
    end
    chk("R8", "busy never cleared", 1, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] b0, b1;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0; blk_prot = 3'd0;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R1: reset state
    chk("R1", "erase_req after reset", int'(erase_req), 0);
    chk("R1", "miso after reset", int'(miso), 0);
    expect_status("R1", 8'h00);

    // R5: erases without the write-enable latch
    do_se(24'h123456, 0);
    do_be(0);
    tick(40);
    expect_status("R5", 8'h00);

    // R2 / R12: set the latch, read status twice in one frame
    do_wren();
    expect_status("R2", 8'h02);
    sel(); send_bits(8'h05, 8); get_byte(b0); get_byte(b1); desel();
    chk("R12", "first repeated status", int'(b0), 8'h02);
    chk("R12", "second repeated status", int'(b1), 8'h02);

    // R6: malformed frames are discarded
    sel(); send_bits(8'hD8, 8); send_bits(8'h12, 8); send_bits(8'h34, 8); desel();
    sel(); send_bits(8'hD8, 8); send_bits(8'h12, 8); send_bits(8'h34, 8);
    send_bits(8'h56, 8); send_bits(8'hA0, 3); desel();
    sel(); send_bits(8'hC7, 8); send_bits(8'h00, 8); desel();
    sel(); send_bits(8'hC7, 7); desel();
    tick(40);
    expect_status("R6", 8'h02);

    // R7: full sector frame but select held low
    begin
      exp_t e;
      sel();
      send_bits(8'hD8, 8); send_bits(8'h3A, 8); send_bits(8'hFF, 8); send_bits(8'h01, 8);
      tick(40);
      chk("R7", "erase_req while select low", int'(erase_req), 0);
      e.all = 0; e.sec = 8'h3A; e.len = SE_C;
      sb_q.push_back(e);
      desel();
    end
    // R8 / R9: busy set, latch cleared
    expect_status("R9", 8'h01);
    // R11: write enable ignored while busy
    do_wren();
    expect_status("R11", 8'h01);
    do_se(24'h050000, 0);
    wait_idle();
    expect_status("R8", 8'h00);

    // R3: low address bits ignored
    do_wren();
    do_se(24'h80FFFF, 1);
    expect_status("R8", 8'h01);
    wait_idle();

    // R4: whole-array erase
    do_wren();
    do_be(1);
    expect_status("R8", 8'h01);
    wait_idle();
    expect_status("R4", 8'h00);

    // R10: protection level 1 locks sectors 252..255
    blk_prot = 3'd1;
    do_wren();
    expect_status("R2", 8'h06);
    do_se(24'hFC0000, 0);
    tick(40);
    expect_status("R10", 8'h06);
    do_se(24'hFB1234, 1);
    expect_status("R10", 8'h05);
    wait_idle();
    do_wren();
    do_be(0);
    tick(40);
    expect_status("R10", 8'h06);
    blk_prot = 3'd7;
    tick(4);
    do_se(24'h000000, 0);
    tick(40);
    expect_status("R10", 8'h1E);
    blk_prot = 3'd0;
    tick(4);
    expect_status("R10", 8'h02);
    do_se(24'h00ABCD, 1);
    wait_idle();
    expect_status("R9", 8'h00);

    tick(100);
    chk("R5", "pending expected erases", sb_q.size(), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule